// File: doc/BRIEF.md
# Multichannel ADC Scan Sequencer

This block is a synchronous master for an external eight-input successive-approximation converter with a latched channel address, a start strobe, an end-of-conversion flag and an output-enabled parallel data bus. It works through the inputs one conversion at a time. For each conversion it drives the channel address, waits out the setup time, and pulses the address latch strobe and the start strobe together. It then keeps the address steady while the conversion runs and waits for the end-of-conversion flag to drop and then to rise again. After that it enables the converter's output, waits out the bus access time and captures the result.

Each capture is delivered as one result word. The word carries the 3-bit channel tag and a single-cycle valid pulse. The sequencer runs in one of two modes. In scan mode it visits the channels set in a mask, going upward and wrapping round. In fixed mode it converts one selected channel again and again. Every timing minimum is a parameter counted in system-clock cycles. The end-of-conversion flag is passed through a synchronizer. A downstream consumer can hold off the next conversion with a ready input. If the flag never falls, or never rises again, a timeout raises an error pulse and the sequencer goes on to the next channel.

Top module: `adc_scan_seq`

## Requirements
- R1: While reset is low, the latch strobe, start, output enable, result valid and error outputs are all low, and the address output reads channel 7 (binary 111).
- R2: The address is held unchanged for at least SETUP_CYC cycles before the latch strobe rises. It then stays unchanged until that conversion's result or error is reported.
- R3: The latch strobe and start are driven high together for exactly PULSE_CYC cycles per conversion.
- R4: A conversion counts as complete only after the synchronized end-of-conversion flag has been seen low and then high. A high level that lasts past the start pulse is not taken as completion.
- R5: Output enable is high for exactly OE_CYC cycles, and never at the same time as start. The data bus is sampled at the last of those cycles.
- R6: Each capture gives a single-cycle res_valid, with res_data equal to the converted value and res_chan equal to the channel number in binary (input k is k).
- R7: In scan mode (cfg_scan=1) the channels set in cfg_mask are converted in ascending order, wrapping back to the lowest set channel. The first one after reset is the lowest set channel.
- R8: In scan mode with an all-zero mask, no conversion is started and no result is reported.
- R9: In fixed mode (cfg_scan=0) every conversion uses the channel on cfg_chan.
- R10: While res_ready is low, no new conversion is started.
- R11: If the flag stays high for TIMEOUT_CYC cycles after the hold phase, or stays low for TIMEOUT_CYC cycles after falling, a one-cycle err_timeout is reported with err_chan. No res_valid is given for that channel, and the sequencer goes on to the next channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_scan | input | 1 | 1 = mask scan, 0 = fixed channel |
| cfg_mask | input | NUM_CH | Channels included in the scan |
| cfg_chan | input | CH_W | Channel used in fixed mode |
| adc_addr | output | CH_W | Channel address to the converter |
| adc_ale | output | 1 | Address latch strobe |
| adc_start | output | 1 | Start-of-conversion strobe |
| adc_eoc | input | 1 | End-of-conversion flag (asynchronous) |
| adc_oe | output | 1 | Converter output enable |
| adc_data | input | DATA_W | Converter data bus |
| res_valid | output | 1 | One-cycle result strobe |
| res_chan | output | CH_W | Channel tag of the result |
| res_data | output | DATA_W | Captured conversion value |
| res_ready | input | 1 | Consumer permits the next conversion |
| err_timeout | output | 1 | One-cycle timeout error strobe |
| err_chan | output | CH_W | Channel that timed out |

## Verification
The bench drives a behavioural converter model and uses several scan masks. One sparse mask exercises skipping and wrap-round. Single-bit masks at both ends check that the scan wraps onto the same channel. The all-zero mask must produce nothing. Fixed-mode runs show that the mask is ignored there. The model's end-of-conversion lag is set short, zero and long, and the model returns a junk value until the conversion has ended, so any early read shows up as a data mismatch. A channel whose flag never falls and a channel whose flag never rises separate the two timeout paths from normal completion. Holding ready low while a mask is enabled shows that the stall takes effect.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [2:0] {
        ST_PICK,
        ST_SETUP,
        ST_PULSE,
        ST_HOLD,
        ST_WFALL,
        ST_WRISE,
        ST_READ
    } seq_state_e;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/adc_seq_sync.sv
module adc_seq_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sh_q <= RESET_VAL;
                else        sh_q <= d;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sh_q <= {STAGES{RESET_VAL}};
                else        sh_q <= {sh_q[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = sh_q[STAGES-1];
endmodule

// File: rtl/adc_seq_pick.sv
module adc_seq_pick #(
    parameter int NUM_CH = 8,
    parameter int CH_W   = 3
) (
    input  logic [NUM_CH-1:0] mask,
    input  logic [CH_W-1:0]   cur,
    output logic [CH_W-1:0]   nxt,
    output logic              any
);
    always_comb begin
        logic found;
        int unsigned idx;
        found = 1'b0;
        nxt   = cur;
        idx   = 0;
        any   = |mask;
        for (int i = 1; i <= NUM_CH; i++) begin
            idx = (int'(cur) + i) % NUM_CH;
            if (!found && mask[idx]) begin
                nxt   = CH_W'(idx);
                found = 1'b1;
            end
        end
    end
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
    import adc_seq_pkg::*;
#(
    parameter int NUM_CH      = 8,
    parameter int DATA_W      = 8,
    parameter int SETUP_CYC   = 5,
    parameter int PULSE_CYC   = 20,
    parameter int HOLD_CYC    = 5,
    parameter int OE_CYC      = 26,
    parameter int TIMEOUT_CYC = 12000,
    parameter int SYNC_STAGES = 2,
    localparam int CH_W       = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_scan,
    input  logic [NUM_CH-1:0] cfg_mask,
    input  logic [CH_W-1:0]   cfg_chan,
    output logic [CH_W-1:0]   adc_addr,
    output logic              adc_ale,
    output logic              adc_start,
    input  logic              adc_eoc,
    output logic              adc_oe,
    input  logic [DATA_W-1:0] adc_data,
    output logic              res_valid,
    output logic [CH_W-1:0]   res_chan,
    output logic [DATA_W-1:0] res_data,
    input  logic              res_ready,
    output logic              err_timeout,
    output logic [CH_W-1:0]   err_chan
);
    localparam int T_MAX = max2(max2(SETUP_CYC, PULSE_CYC),
                                max2(max2(HOLD_CYC, OE_CYC), TIMEOUT_CYC));
    localparam int TMR_W = $clog2(T_MAX + 1);
    localparam logic [TMR_W-1:0] LD_SETUP = TMR_W'(SETUP_CYC - 1);
    localparam logic [TMR_W-1:0] LD_PULSE = TMR_W'(PULSE_CYC - 1);
    localparam logic [TMR_W-1:0] LD_HOLD  = TMR_W'(HOLD_CYC - 1);
    localparam logic [TMR_W-1:0] LD_OE    = TMR_W'(OE_CYC - 1);
    localparam logic [TMR_W-1:0] LD_TO    = TMR_W'(TIMEOUT_CYC - 1);

    typedef struct packed {
        seq_state_e        st;
        logic [TMR_W-1:0]  tmr;
        logic [CH_W-1:0]   ch;
        logic              ale;
        logic              oe;
        logic              vld;
        logic              err;
        logic [DATA_W-1:0] data;
    } seq_regs_t;

    seq_regs_t r_d, r_q;
    logic eoc_sync;
    logic [CH_W-1:0] pick_nxt;
    logic pick_any;

    adc_seq_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(adc_eoc), .q(eoc_sync)
    );

    adc_seq_pick #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_pick (
        .mask(cfg_mask), .cur(r_q.ch), .nxt(pick_nxt), .any(pick_any)
    );

    always_comb begin
        r_d     = r_q;
        r_d.vld = 1'b0;
        r_d.err = 1'b0;
        case (r_q.st)
            ST_PICK: begin
                if (res_ready && (!cfg_scan || pick_any)) begin
                    r_d.ch  = cfg_scan ? pick_nxt : cfg_chan;
                    r_d.st  = ST_SETUP;
                    r_d.tmr = LD_SETUP;
                end
            end
            ST_SETUP: begin
                if (r_q.tmr == '0) begin
                    r_d.st  = ST_PULSE;
                    r_d.tmr = LD_PULSE;
                    r_d.ale = 1'b1;
                end else begin
                    r_d.tmr = r_q.tmr - 1'b1;
                end
            end
            ST_PULSE: begin
                if (r_q.tmr == '0) begin
                    r_d.st  = ST_HOLD;
                    r_d.tmr = LD_HOLD;
                    r_d.ale = 1'b0;
                end else begin
                    r_d.tmr = r_q.tmr - 1'b1;
                end
            end
            ST_HOLD: begin
                if (r_q.tmr == '0) begin
                    r_d.st  = ST_WFALL;
                    r_d.tmr = LD_TO;
                end else begin
                    r_d.tmr = r_q.tmr - 1'b1;
                end
            end
            ST_WFALL: begin
                if (!eoc_sync) begin
                    r_d.st  = ST_WRISE;
                    r_d.tmr = LD_TO;
                end else if (r_q.tmr == '0) begin
                    r_d.st  = ST_PICK;
                    r_d.err = 1'b1;
                end else begin
                    r_d.tmr = r_q.tmr - 1'b1;
                end
            end
            ST_WRISE: begin
                if (eoc_sync) begin
                    r_d.st  = ST_READ;
                    r_d.tmr = LD_OE;
                    r_d.oe  = 1'b1;
                end else if (r_q.tmr == '0) begin
                    r_d.st  = ST_PICK;
                    r_d.err = 1'b1;
                end else begin
                    r_d.tmr = r_q.tmr - 1'b1;
                end
            end
            ST_READ: begin
                if (r_q.tmr == '0) begin
                    r_d.st   = ST_PICK;
                    r_d.oe   = 1'b0;
                    r_d.vld  = 1'b1;
                    r_d.data = adc_data;
                end else begin
                    r_d.tmr = r_q.tmr - 1'b1;
                end
            end
            default: r_d.st = ST_PICK;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st   <= ST_PICK;
            r_q.tmr  <= '0;
            r_q.ch   <= CH_W'(NUM_CH - 1);
            r_q.ale  <= 1'b0;
            r_q.oe   <= 1'b0;
            r_q.vld  <= 1'b0;
            r_q.err  <= 1'b0;
            r_q.data <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign adc_addr    = r_q.ch;
    assign adc_ale     = r_q.ale;
    assign adc_start   = r_q.ale;
    assign adc_oe      = r_q.oe;
    assign res_valid   = r_q.vld;
    assign res_chan    = r_q.ch;
    assign res_data    = r_q.data;
    assign err_timeout = r_q.err;
    assign err_chan    = r_q.ch;

    // Checker state for the assertions below.
    logic [CH_W-1:0]  addr_prev_q;
    logic [TMR_W-1:0] setup_run_q;
    logic [TMR_W-1:0] ale_run_q;
    logic             low_seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_prev_q <= CH_W'(NUM_CH - 1);
            setup_run_q <= TMR_W'(T_MAX);
            ale_run_q   <= '0;
            low_seen_q  <= 1'b0;
        end else begin
            addr_prev_q <= adc_addr;
            if (adc_addr != addr_prev_q)       setup_run_q <= TMR_W'(1);
            else if (setup_run_q != TMR_W'(T_MAX)) setup_run_q <= setup_run_q + 1'b1;
            ale_run_q <= adc_ale ? ale_run_q + 1'b1 : '0;
            if (adc_start)      low_seen_q <= 1'b0;
            else if (!eoc_sync) low_seen_q <= 1'b1;
        end
    end

    p_addr_setup_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(adc_ale) |-> (setup_run_q >= TMR_W'(SETUP_CYC)));

    p_addr_moves_only_from_pick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(adc_addr) |-> ($past(r_q.st) == ST_PICK));

    p_pulse_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(adc_ale) |-> (ale_run_q == TMR_W'(PULSE_CYC)));

    p_done_after_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(adc_oe) |-> low_seen_q);

    p_oe_not_with_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(adc_oe && adc_start));

    p_valid_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    p_zero_mask_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_PICK && cfg_scan && cfg_mask == '0) |=> (r_q.st == ST_PICK));

    p_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_PICK && !res_ready) |=> !adc_ale && (r_q.st == ST_PICK));

    p_err_no_valid_r11: assert property (@(posedge clk) disable iff (!rst_n)
        err_timeout |-> !res_valid);

endmodule

// File: tb/tb_adc_scan_seq.sv
`timescale 1ns/1ps
module tb_adc_scan_seq;
    localparam int SETUP = 3, PULSE = 4, HOLD = 3, OEC = 3, TMO = 150;
    localparam int CONV = 30, OE_LAT = 2;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic       rst_n = 1'b0;
    logic       cfg_scan = 1'b1;
    logic [7:0] cfg_mask = 8'h00;
    logic [2:0] cfg_chan = 3'd0;
    logic [2:0] adc_addr;
    logic       adc_ale, adc_start, adc_oe;
    logic       eoc_m = 1'b1;
    logic [7:0] adc_data;
    logic       res_valid, err_timeout;
    logic [2:0] res_chan, err_chan;
    logic [7:0] res_data;
    logic       res_ready = 1'b0;

    adc_scan_seq #(.NUM_CH(8), .DATA_W(8), .SETUP_CYC(SETUP), .PULSE_CYC(PULSE),
                   .HOLD_CYC(HOLD), .OE_CYC(OEC), .TIMEOUT_CYC(TMO), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_scan(cfg_scan), .cfg_mask(cfg_mask),
        .cfg_chan(cfg_chan), .adc_addr(adc_addr), .adc_ale(adc_ale),
        .adc_start(adc_start), .adc_eoc(eoc_m), .adc_oe(adc_oe), .adc_data(adc_data),
        .res_valid(res_valid), .res_chan(res_chan), .res_data(res_data),
        .res_ready(res_ready), .err_timeout(err_timeout), .err_chan(err_chan)
    );

    int n_checks = 0, n_errs = 0;
    bit finished = 0;

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // Behavioural converter model
    logic [7:0] model_val [8];
    int eoc_lag = 4, dead_ch = -1, stuck_ch = -1;
    logic start_p = 1'b0, ale_p = 1'b0;
    logic [2:0] lat_ch = 3'd0;
    logic [7:0] dreg = 8'hEE;
    int phase = 0, cnt = 0, oe_cnt = 0;

    always @(posedge clk) begin
        start_p <= adc_start;
        ale_p   <= adc_ale;
        if (adc_ale && !ale_p) lat_ch <= adc_addr;
        oe_cnt  <= adc_oe ? oe_cnt + 1 : 0;
        if (adc_start && !start_p) begin
            eoc_m <= 1'b1; dreg <= 8'hEE; phase <= 0;
        end else if (!adc_start && start_p) begin
            phase <= 1; cnt <= eoc_lag;
        end else if (phase == 1) begin
            if (int'(lat_ch) != dead_ch) begin
                if (cnt == 0) begin eoc_m <= 1'b0; phase <= 2; cnt <= CONV; end
                else cnt <= cnt - 1;
            end
        end else if (phase == 2) begin
            if (int'(lat_ch) != stuck_ch) begin
                if (cnt == 0) begin eoc_m <= 1'b1; dreg <= model_val[lat_ch]; phase <= 0; end
                else cnt <= cnt - 1;
            end
        end
    end
    assign adc_data = (adc_oe && oe_cnt >= OE_LAT) ? dreg : 8'hEE;

    // Scoreboard
    typedef struct { bit err; logic [2:0] ch; logic [7:0] data; } item_t;
    item_t exp_q[$];
    int last_ch = 7;
    int ale_rises = 0, vld_seen = 0;

    logic [2:0] addr_prev = 3'd7;
    int stable_n = 0, ale_w = 0, oe_w = 0;
    bit busy = 0, moved = 0, st_mis = 0, oe_ale = 0, ale_prev = 0, oe_prev = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (adc_addr !== addr_prev) begin
                stable_n = 0;
                if (busy) moved = 1;
            end else stable_n++;
            if (adc_start !== adc_ale) st_mis = 1;
            if (adc_ale && !ale_prev) begin
                check(stable_n >= SETUP, "R2 address setup before strobe", stable_n, SETUP);
                busy = 1; moved = 0; ale_w = 1; ale_rises++;
            end else if (adc_ale) ale_w++;
            if (!adc_ale && ale_prev) begin
                check(ale_w == PULSE && !st_mis, "R3 strobe width / start with strobe", ale_w, PULSE);
                st_mis = 0;
            end
            if (adc_oe) begin
                oe_w++;
                if (adc_start) oe_ale = 1;
            end
            if (!adc_oe && oe_prev) begin
                check(oe_w == OEC && !oe_ale, "R5 output enable width", oe_w, OEC);
                oe_w = 0; oe_ale = 0;
            end
            if (res_valid || err_timeout) begin
                vld_seen++;
                check(!moved, "R2 address held through conversion", moved, 0);
                busy = 0;
                if (exp_q.size() == 0) begin
                    check(0, "R6 unexpected result", res_chan, 0);
                end else begin
                    item_t it;
                    it = exp_q.pop_front();
                    if (it.err) begin
                        check(err_timeout && !res_valid && err_chan == it.ch,
                              "R11 timeout report", {err_timeout, 5'd0, err_chan}, {1'b1, 5'd0, it.ch});
                    end else begin
                        check(res_valid && res_chan == it.ch, "R6/R7 result channel", res_chan, it.ch);
                        check(res_data === it.data, "R4/R6 result data", res_data, it.data);
                    end
                    if (exp_q.size() == 0) res_ready = 1'b0;
                end
            end
            if (res_valid) begin
                @(negedge clk);
                check(!res_valid, "R6 valid is one cycle", res_valid, 0);
                addr_prev = adc_addr; ale_prev = adc_ale; oe_prev = adc_oe;
            end else begin
                addr_prev = adc_addr; ale_prev = adc_ale; oe_prev = adc_oe;
            end
        end
    end

    function automatic int next_en(input logic [7:0] m, input int last);
        for (int i = 1; i <= 8; i++) begin
            if (m[(last + i) % 8]) return (last + i) % 8;
        end
        return last;
    endfunction

    task automatic run_items(input int n);
        for (int k = 0; k < n; k++) begin
            item_t it;
            int c;
            c = cfg_scan ? next_en(cfg_mask, last_ch) : int'(cfg_chan);
            it.ch   = 3'(c);
            it.err  = (c == dead_ch) || (c == stuck_ch);
            it.data = model_val[c];
            exp_q.push_back(it);
            last_ch = c;
        end
        @(negedge clk);
        res_ready = 1'b1;
        while (exp_q.size() != 0) @(posedge clk);
        repeat (5) @(negedge clk);
    endtask

    task automatic finish_up;
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_errs++; n_checks++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", exp_q.size(), 0);
            finish_up();
        end
    end

    initial begin
        int r0;
        for (int i = 0; i < 8; i++) model_val[i] = 8'(8'h11 * i + 8'h05);
        repeat (4) @(negedge clk);
        // R1: reset state
        check(!adc_ale && !adc_start && !adc_oe, "R1 strobes low in reset", {adc_ale, adc_start, adc_oe}, 0);
        check(!res_valid && !err_timeout, "R1 no result in reset", {res_valid, err_timeout}, 0);
        check(adc_addr == 3'b111, "R1 reset address", adc_addr, 7);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);

        // R7: sparse mask 1,2,5,7 with wrap, first is lowest
        cfg_scan = 1'b1; cfg_mask = 8'b1010_0110;
        run_items(6);

        // R9: fixed channel 3 ignores mask
        cfg_scan = 1'b0; cfg_chan = 3'd3;
        for (int i = 0; i < 8; i++) model_val[i] = 8'(8'hA0 ^ (i * 8'h17));
        run_items(3);

        // R7 single-bit masks at both ends, R4 with long lag
        eoc_lag = 12;
        cfg_scan = 1'b1; cfg_mask = 8'h80;
        run_items(2);
        cfg_mask = 8'h01; model_val[0] = 8'h00;
        run_items(2);
        eoc_lag = 4;

        // R8: zero mask idle
        cfg_mask = 8'h00;
        r0 = ale_rises;
        @(negedge clk); res_ready = 1'b1;
        repeat (300) @(negedge clk);
        check(ale_rises == r0, "R8 no start with empty mask", ale_rises - r0, 0);
        check(!res_valid && exp_q.size() == 0, "R8 no result with empty mask", res_valid, 0);
        res_ready = 1'b0;
        @(negedge clk);

        // R10: stall while ready low
        cfg_mask = 8'h0F;
        r0 = ale_rises;
        repeat (100) @(negedge clk);
        check(ale_rises == r0, "R10 no start while ready low", ale_rises - r0, 0);
        run_items(4);

        // R11: flag never falls on channel 4
        for (int i = 0; i < 8; i++) model_val[i] = 8'(8'h3C + i * 8'h21);
        model_val[6] = 8'hFF;
        dead_ch = 4; cfg_mask = 8'h50;
        run_items(3);
        // R11: flag never rises again on channel 6
        dead_ch = -1; stuck_ch = 6;
        run_items(3);
        stuck_ch = -1;
        run_items(2);

        // R4 with zero lag, fixed channel 0
        eoc_lag = 0; cfg_scan = 1'b0; cfg_chan = 3'd0; model_val[0] = 8'hFF;
        run_items(2);

        finished = 1;
        finish_up();
    end
endmodule